// File: doc/BRIEF.md
# Pipelined Multicast Configuration Bus

This block carries configuration words from one source to several configuration memories over a one-way pipelined bus. The source opens a transfer with a one-cycle start strobe. On that strobe it gives a destination code and a starting word address. It then streams 26-bit words, one per cycle when it has them. Each accepted word goes to the current word address, and that address then advances by one. So a burst fills consecutive words of every memory that the transfer targets.

The destination code selects its targets in one of three ways. It can name a single slave, give a bitmask of slaves, or reach all slaves. A selector stage captures the target set when the transfer starts, and every word of that burst goes to that set. Each slave owns a 12-word by 26-bit memory. The memory's consumer reads it through a combinational read port. A word reaches its memory a fixed five cycles after the source presents it, and back-to-back words give one write per cycle. A word addressed past the last memory word is discarded, and an error flag records it.

Top module: `cfg_bus`

## Requirements
- R1: After reset, every word of every slave memory reads 0 and `err_o` is 0.
- R2: A word accepted at clock edge t is written at edge t+5. It is visible on `rd_data_o` after edge t+5 and not after edge t+4.
- R3: The accepted words of one transfer go to consecutive word addresses, starting at the `base_addr_i` value captured with `xfer_init_i`.
- R4: Words given on consecutive cycles are all written, one per cycle. A cycle with `data_en_i` low neither writes a word nor advances the address.
- R5: A destination code with bits [7:6]=00 targets only the slave whose index equals bits [5:0]. An index of `N_SLAVES` or more targets no slave.
- R6: A destination code with bits [7:6]=01 targets every slave k for which bit k of the code is 1.
- R7: A destination code with bit 7 = 1 targets all slaves.
- R8: The target set is captured only on `xfer_init_i`. A change of `dest_i` without a start strobe has no effect. A new start does not redirect words that are already in flight.
- R9: A word whose address is 12 or more is discarded, and `err_o` becomes 1 after the edge that accepts it. The next `xfer_init_i` clears `err_o`.
- R10: A word is accepted only when `xfer_en_i` and `data_en_i` are high in an open transfer. The start cycle itself accepts no word. A cycle with `xfer_en_i` low closes the transfer until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_init_i | input | 1 | Start strobe; captures dest_i and base_addr_i |
| xfer_en_i | input | 1 | Transfer enable; low closes the transfer |
| data_en_i | input | 1 | Data word valid |
| dest_i | input | 8 | Destination code: [7]=all, [7:6]=01 mask in [5:0], [7:6]=00 index in [5:0] |
| base_addr_i | input | 8 | First word address of the burst |
| data_i | input | 26 | Configuration word |
| rd_addr_i | input | N_SLAVES*4 | Read word address per slave, slave k in bits [4k+3:4k] |
| rd_data_o | output | N_SLAVES*26 | Read data per slave, slave k in bits [26k+25:26k] |
| err_o | output | 1 | Sticky address-overrun flag |

## Verification
A word sampled at edge t must be seen on the read port after edge t+5, and not after edge t+4. The bench reads at the falling edges that follow both of those rising edges. `err_o` is due just after the edge that accepts the discarded word, and its clearing is due just after the start edge. The bench samples it at the next falling edge. For each burst, the bench waits six cycles after the last word and only then compares every memory word with its own model.

// File: rtl/cfg_bus_pkg.sv
package cfg_bus_pkg;
  localparam int DATA_W    = 26;
  localparam int ADDR_W    = 8;
  localparam int DEST_W    = 8;
  localparam int MEM_DEPTH = 12;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);
  localparam int FIELD_W   = DEST_W - 2;

  typedef enum logic [1:0] {
    DM_UNI   = 2'b00,
    DM_MULTI = 2'b01,
    DM_ALL_A = 2'b10,
    DM_ALL_B = 2'b11
  } dest_mode_e;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cfg_word_t;
endpackage

// File: rtl/cfg_master_if.sv
module cfg_master_if
  import cfg_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              tx_en_i,
  input  logic              data_en_i,
  input  logic [DATA_W-1:0] data_i,
  output cfg_word_t         word_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(MEM_DEPTH - 1);

  logic              open_q;
  logic [ADDR_W-1:0] addr_q;
  cfg_word_t         word_q;
  logic              err_q;
  logic              accept;

  assign accept = open_q && tx_en_i && data_en_i && !init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      addr_q <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else if (init_i) begin
      open_q     <= 1'b1;
      addr_q     <= base_i;
      err_q      <= 1'b0;
      word_q.vld <= 1'b0;
    end else begin
      open_q      <= open_q && tx_en_i;
      word_q.vld  <= 1'b0;
      word_q.addr <= addr_q;
      word_q.data <= data_i;
      if (accept) begin
        if (addr_q <= LAST_A) word_q.vld <= 1'b1;
        else                  err_q      <= 1'b1;
        // saturate so a long overrun never wraps back into range
        if (addr_q != '1) addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign word_o = word_q;
  assign err_o  = err_q;
endmodule

// File: rtl/cfg_selector.sv
module cfg_selector
  import cfg_bus_pkg::*;
#(
  parameter int N_SLAVES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic [DEST_W-1:0]   dest_i,
  input  cfg_word_t           word_i,
  output cfg_word_t           word_o,
  output logic [N_SLAVES-1:0] sel_o,
  output logic [N_SLAVES-1:0] mask_o
);
  logic [N_SLAVES-1:0] mask_d, mask_q, sel_q;
  cfg_word_t           word_q;
  dest_mode_e          mode;

  assign mode = dest_mode_e'(dest_i[DEST_W-1 -: 2]);

  always_comb begin
    mask_d = '0;
    for (int k = 0; k < N_SLAVES; k++) begin
      unique case (mode)
        DM_UNI:   mask_d[k] = (dest_i[FIELD_W-1:0] == FIELD_W'(k));
        DM_MULTI: mask_d[k] = (k < FIELD_W) ? dest_i[k % FIELD_W] : 1'b0;
        default:  mask_d[k] = 1'b1;
      endcase
    end
  end

  // mask_q updates on the start edge; the word captured on that edge still sees the old mask
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      sel_q  <= '0;
      word_q <= '0;
    end else begin
      if (init_i) mask_q <= mask_d;
      sel_q  <= mask_q;
      word_q <= word_i;
    end
  end

  assign word_o = word_q;
  assign sel_o  = sel_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/cfg_bus_pipe.sv
module cfg_bus_pipe
  import cfg_bus_pkg::*;
#(
  parameter int N_SLAVES = 4,
  parameter int STAGES   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  cfg_word_t           word_i,
  input  logic [N_SLAVES-1:0] sel_i,
  output cfg_word_t           word_o,
  output logic [N_SLAVES-1:0] sel_o
);
  if (STAGES == 0) begin : gen_wire
    assign word_o = word_i;
    assign sel_o  = sel_i;
  end else begin : gen_regs
    cfg_word_t           word_q [STAGES];
    logic [N_SLAVES-1:0] sel_q  [STAGES];
    for (genvar s = 0; s < STAGES; s++) begin : gen_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          word_q[s] <= '0;
          sel_q[s]  <= '0;
        end else if (s == 0) begin
          word_q[s] <= word_i;
          sel_q[s]  <= sel_i;
        end else begin
          word_q[s] <= word_q[(s == 0) ? 0 : s-1];
          sel_q[s]  <= sel_q[(s == 0) ? 0 : s-1];
        end
      end
    end
    assign word_o = word_q[STAGES-1];
    assign sel_o  = sel_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_slave_if.sv
module cfg_slave_if
  import cfg_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_word_t         word_i,
  input  logic              sel_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_en_o
);
  cfg_word_t         cap_q;
  logic              cap_sel_q;
  logic              wr_q;
  logic [MEM_AW-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [DATA_W-1:0] mem_q [MEM_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q     <= '0;
      cap_sel_q <= 1'b0;
      wr_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      cap_q     <= word_i;
      cap_sel_q <= sel_i;
      wr_q      <= cap_q.vld && cap_sel_q;
      wr_addr_q <= cap_q.addr[MEM_AW-1:0];
      wr_data_q <= cap_q.data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_q) begin
      mem_q[wr_addr_q] <= wr_data_q;
    end
  end

  assign rd_data_o = (32'(rd_addr_i) < MEM_DEPTH) ? mem_q[rd_addr_i] : '0;
  assign wr_en_o   = wr_q;
endmodule

// File: rtl/cfg_bus.sv
module cfg_bus
  import cfg_bus_pkg::*;
#(
  parameter int N_SLAVES    = 4,
  parameter int PIPE_STAGES = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       xfer_init_i,
  input  logic                       xfer_en_i,
  input  logic                       data_en_i,
  input  logic [DEST_W-1:0]          dest_i,
  input  logic [ADDR_W-1:0]          base_addr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic [N_SLAVES*MEM_AW-1:0] rd_addr_i,
  output logic [N_SLAVES*DATA_W-1:0] rd_data_o,
  output logic                       err_o
);
  cfg_word_t           m_word, s_word, b_word;
  logic [N_SLAVES-1:0] s_sel, b_sel, sel_mask, wr_en;
  logic                m_vld;
  logic [ADDR_W-1:0]   m_addr;

  assign m_vld  = m_word.vld;
  assign m_addr = m_word.addr;

  cfg_master_if u_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (xfer_init_i),
    .base_i    (base_addr_i),
    .tx_en_i   (xfer_en_i),
    .data_en_i (data_en_i),
    .data_i    (data_i),
    .word_o    (m_word),
    .err_o     (err_o)
  );

  cfg_selector #(.N_SLAVES(N_SLAVES)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (xfer_init_i),
    .dest_i (dest_i),
    .word_i (m_word),
    .word_o (s_word),
    .sel_o  (s_sel),
    .mask_o (sel_mask)
  );

  cfg_bus_pipe #(.N_SLAVES(N_SLAVES), .STAGES(PIPE_STAGES)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (s_word),
    .sel_i  (s_sel),
    .word_o (b_word),
    .sel_o  (b_sel)
  );

  for (genvar k = 0; k < N_SLAVES; k++) begin : gen_slave
    cfg_slave_if u_slave (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .word_i    (b_word),
      .sel_i     (b_sel[k]),
      .rd_addr_i (rd_addr_i[k*MEM_AW +: MEM_AW]),
      .rd_data_o (rd_data_o[k*DATA_W +: DATA_W]),
      .wr_en_o   (wr_en[k])
    );
  end
endmodule

// File: rtl/cfg_bus_chk.sv
module cfg_bus_chk
  import cfg_bus_pkg::*;
#(
  parameter int N_SLAVES    = 4,
  parameter int PIPE_STAGES = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                init_i,
  input logic                tx_en_i,
  input logic                err_i,
  input logic                m_vld_i,
  input logic [ADDR_W-1:0]   m_addr_i,
  input logic [N_SLAVES-1:0] mask_i,
  input logic [N_SLAVES-1:0] wr_en_i
);
  localparam int LAG = 3 + PIPE_STAGES;

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_i) |-> $past(m_vld_i, LAG));

  assert_burst_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_vld_i && $past(m_vld_i)) |-> (m_addr_i == $past(m_addr_i) + 1'b1));

  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> $stable(mask_i));

  assert_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_vld_i |-> (32'(m_addr_i) < MEM_DEPTH));

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !err_i);

  assert_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !m_vld_i);
endmodule

bind cfg_bus cfg_bus_chk #(.N_SLAVES(N_SLAVES), .PIPE_STAGES(PIPE_STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .init_i   (xfer_init_i),
  .tx_en_i  (xfer_en_i),
  .err_i    (err_o),
  .m_vld_i  (m_vld),
  .m_addr_i (m_addr),
  .mask_i   (sel_mask),
  .wr_en_i  (wr_en)
);

// File: tb/sim_cfg_bus.sv
module sim_cfg_bus;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int DW = 26;
  localparam int AW = 4;
  localparam int DEPTH = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic xfer_init = 1'b0, xfer_en = 1'b0, data_en = 1'b0;
  logic [7:0] dest = '0, base = '0;
  logic [DW-1:0] data = '0;
  logic [NS*AW-1:0] rd_addr = '0;
  logic [NS*DW-1:0] rd_data;
  logic err;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_mem [NS][DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bus #(.N_SLAVES(NS), .PIPE_STAGES(1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_init_i(xfer_init), .xfer_en_i(xfer_en),
    .data_en_i(data_en), .dest_i(dest), .base_addr_i(base), .data_i(data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .err_o(err)
  );

  // dest, base, word count, seed
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'd0,  8'd12, 8'd1},
    {8'h03, 8'd4,  8'd5,  8'd2},
    {8'h45, 8'd2,  8'd6,  8'd3},
    {8'h80, 8'd7,  8'd5,  8'd4},
    {8'h09, 8'd0,  8'd3,  8'd5},
    {8'h4A, 8'd10, 8'd2,  8'd6}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [NS-1:0] tmask(input logic [7:0] d);
    logic [NS-1:0] m = '0;
    if (d[7]) m = '1;
    else if (d[6]) m = d[NS-1:0];
    else if (d[5:0] < NS) m[d[1:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] dval(input int seed, input int i);
    return DW'(seed * 40503 + i * 499 + 17);
  endfunction

  function automatic logic [DW-1:0] rd(input int k);
    return rd_data[k*DW +: DW];
  endfunction

  task automatic model(input logic [7:0] d, input int a, input logic [DW-1:0] v);
    logic [NS-1:0] m = tmask(d);
    if (a < DEPTH)
      for (int k = 0; k < NS; k++) if (m[k]) exp_mem[k][a] = v;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 0; k < NS; k++) rd_addr[k*AW +: AW] = AW'(a);
      #1;
      for (int k = 0; k < NS; k++)
        chk(rd(k) === exp_mem[k][a], req, 32'(rd(k)), 32'(exp_mem[k][a]));
    end
  endtask

  task automatic start(input logic [7:0] d, input logic [7:0] b);
    xfer_init = 1'b1; dest = d; base = b; xfer_en = 1'b1; data_en = 1'b0;
    step();
    xfer_init = 1'b0;
  endtask

  task automatic word(input logic [DW-1:0] v);
    data_en = 1'b1; data = v;
    step();
    data_en = 1'b0;
  endtask

  task automatic finish_xfer();
    xfer_en = 1'b0; data_en = 1'b0;
    repeat (6) step();
  endtask

  initial begin
    for (int k = 0; k < NS; k++) for (int a = 0; a < DEPTH; a++) exp_mem[k][a] = '0;
    repeat (3) step();
    // R1 reset state
    check_all("R1");
    chk(err === 1'b0, "R1", 32'(err), 0);
    rst_ni = 1'b1;
    step();

    // vector table: R3 R4 R5 R6 R7 bursts
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d = VEC[v][31:24];
      int b = int'(VEC[v][23:16]);
      int n = int'(VEC[v][15:8]);
      int s = int'(VEC[v][7:0]);
      start(d, 8'(b));
      for (int i = 0; i < n; i++) begin
        word(dval(s, i));
        model(d, b + i, dval(s, i));
      end
      finish_xfer();
      check_all("R3/R5/R6/R7 vector");
    end

    // R2 exact latency: unicast slave 2, addr 5
    begin
      logic [DW-1:0] v = dval(50, 1);
      start(8'h02, 8'd5);
      word(v);
      repeat (4) step();
      rd_addr[2*AW +: AW] = 4'd5; #1;
      chk(rd(2) === exp_mem[2][5], "R2 early", 32'(rd(2)), 32'(exp_mem[2][5]));
      step();
      rd_addr[2*AW +: AW] = 4'd5; #1;
      chk(rd(2) === v, "R2 due", 32'(rd(2)), 32'(v));
      exp_mem[2][5] = v;
      finish_xfer();
    end

    // R4 gaps do not advance the address
    start(8'h80, 8'd0);
    word(dval(60, 0)); model(8'h80, 0, dval(60, 0));
    step();
    word(dval(60, 1)); model(8'h80, 1, dval(60, 1));
    step(); step();
    word(dval(60, 2)); model(8'h80, 2, dval(60, 2));
    finish_xfer();
    check_all("R4");

    // R10 acceptance rules
    xfer_init = 1'b1; dest = 8'h03; base = 8'd0; xfer_en = 1'b1;
    data_en = 1'b1; data = dval(70, 9);   // start cycle: ignored
    step();
    xfer_init = 1'b0; data_en = 1'b0;
    word(dval(70, 0)); model(8'h03, 0, dval(70, 0));
    xfer_en = 1'b0; word(dval(70, 1));   // enable low: ignored, closes
    xfer_en = 1'b1; word(dval(70, 2));   // closed: ignored
    finish_xfer();
    check_all("R10");

    // R8 mask held, dest change ignored, restart does not redirect in-flight words
    start(8'h43, 8'd3);
    word(dval(80, 0)); model(8'h43, 3, dval(80, 0));
    dest = 8'h80;
    word(dval(80, 1)); model(8'h43, 4, dval(80, 1));
    xfer_init = 1'b1; dest = 8'h02; base = 8'd3; xfer_en = 1'b1;
    step();
    xfer_init = 1'b0;
    word(dval(80, 2)); model(8'h02, 3, dval(80, 2));
    finish_xfer();
    check_all("R8");

    // R9 overrun: words at 10,11 written, 12,13 dropped
    start(8'h01, 8'd10);
    word(dval(90, 0)); model(8'h01, 10, dval(90, 0));
    chk(err === 1'b0, "R9 no err in range", 32'(err), 0);
    word(dval(90, 1)); model(8'h01, 11, dval(90, 1));
    word(dval(90, 2));
    chk(err === 1'b1, "R9 err set", 32'(err), 1);
    word(dval(90, 3));
    finish_xfer();
    chk(err === 1'b1, "R9 err sticky", 32'(err), 1);
    check_all("R9 drop");
    xfer_init = 1'b1; dest = 8'h00; base = 8'd0; step();
    xfer_init = 1'b0;
    chk(err === 1'b0, "R9 err cleared", 32'(err), 0);
    // base past the end
    start(8'h80, 8'd12);
    word(dval(95, 0));
    chk(err === 1'b1, "R9 base overrun", 32'(err), 1);
    finish_xfer();
    check_all("R9 base drop");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule